// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing protocol engine of a serial memory device. It runs on a fast system clock and oversamples the SCL and SDA lines of a two-wire bus. It recognises start and stop conditions and accepts a device-select byte. The upper nibble of that byte must be the fixed device code and the next three bits must equal the `strap` pins. After a write select it takes a two-byte word address followed by data bytes. After a read select it shifts out bytes fetched from a read port. The block acknowledges each byte it receives by pulling SDA low through an open-drain enable.

Write data leaves the block one byte at a time on a strobe, tagged with its address. A stop that follows at least one data byte raises a commit pulse, which launches the programming cycle downstream. While that cycle runs, the downstream logic holds `wr_busy` high and the engine declines to acknowledge its own select byte. A host can therefore poll until the select byte is acknowledged again.

Top module: `twm_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and neither `wr_valid` nor `wr_commit` is asserted.
- R2: A select byte is acknowledged (SDA held low through the ninth SCL pulse) only if its bits 7..4 are 1010 and its bits 3..1 equal `strap`. Bit 0 is 1 for read and 0 for write. On a mismatch the engine keeps SDA released, including through later bytes, until the next start condition.
- R3: In a write, the two address bytes that follow the select byte are each acknowledged. The word address is bits 4..0 of the first byte followed by all 8 bits of the second. Bits 7..5 of the first byte are ignored. Each data byte is acknowledged and emitted as one `wr_valid` pulse carrying `wr_addr` and `wr_data`.
- R4: Within a write, the address advances by one after each data byte. Only the low 5 bits (the 32-byte page offset) take part, so offset 31 wraps to offset 0 of the same page.
- R5: A stop condition raises `wr_commit` for one cycle only if the write transfer since the last start delivered at least one data byte. A stop after an address-only write, or after a transfer that a start condition aborted, raises no commit.
- R6: A read select with no address first returns the byte at one past the last accessed address.
- R7: A random read is a write select followed by the two address bytes, a repeated start and a read select. The first byte returned is the one at the address just sent.
- R8: During a read, each master ACK (SDA low on the ninth pulse) causes the byte at the next address to be sent. The address wraps from the top of the 13-bit space to 0. A master NACK ends the transfer, and SDA stays released until the next start condition.
- R9: While `wr_busy` is high the select byte is not acknowledged and no write strobe is produced. Once `wr_busy` is low, the same select byte is acknowledged again.
- R10: A start condition at any point aborts the transfer in progress, releases SDA and begins a new select byte.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low (open drain), 0 releases it |
| strap | input | 3 | Device-select strap pins |
| wr_busy | input | 1 | Downstream programming cycle in progress |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | ADDR_W | Word address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_commit | output | 1 | One-cycle pulse: start programming |
| rd_addr | output | ADDR_W | Read port address (current pointer) |
| rd_data | input | 8 | Read port data for `rd_addr`, combinational |

## Verification
The bench builds the engine with a 13-bit word address, a 5-bit page offset and a strap value of 101. With these values the sequential read crosses the 8191-to-0 boundary in three bytes, and a write starting at page offset 31 wraps within its page after one byte. The select sweep covers all eight strap codes and a wrong device code. The read port returns a pattern computed from the address, so every byte returned can be predicted arithmetically. Busy polling, aborts in mid-byte, and address-only writes are each checked against the write strobe and commit pulse seen at the ports.

// File: rtl/twm_pkg.sv
package twm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } twm_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  // select byte check: fixed code in [7:4], strap in [3:1]
  function automatic logic sel_match(input logic [7:0] sel, input logic [2:0] strap);
    return (sel[7:4] == DEV_CODE) && (sel[3:1] == strap);
  endfunction

  // advance only the in-page offset bits
  function automatic logic [15:0] page_next(input logic [15:0] a, input int unsigned pw);
    logic [15:0] msk;
    msk = 16'((32'd1 << pw) - 32'd1);
    return (a & ~msk) | ((a + 16'd1) & msk);
  endfunction

  // linear advance with wrap to zero at the top of the space
  function automatic logic [15:0] lin_next(input logic [15:0] a, input int unsigned aw);
    logic [15:0] msk;
    msk = 16'((32'd1 << aw) - 32'd1);
    return (a + 16'd1) & msk;
  endfunction

endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_s    = scl_ff[1];
  assign sda_s    = sda_ff[1];
  assign ev_rise  = scl_s & ~scl_q;
  assign ev_fall  = ~scl_s & scl_q;
  assign ev_start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twm_engine.sv
module twm_engine
  import twm_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic [2:0]        strap,
  input  logic              wr_busy,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              byte_done,
  output logic              sel_done
);
  twm_state_e        state;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg, tx, hi;
  logic [ADDR_W-1:0] ptr;
  logic              mack, got_data;
  logic [2:0]        bit_idx;

  assign bit_idx   = 3'(4'd7 - bitcnt);
  assign byte_done = ev_fall && (bitcnt == 4'd8) && (state != ST_IDLE) && (state != ST_RD);
  assign sel_done  = byte_done && (state == ST_DEV);
  assign rd_addr   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      tx        <= '0;
      hi        <= '0;
      ptr       <= '0;
      mack      <= 1'b0;
      got_data  <= 1'b0;
      sda_oe    <= 1'b0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      if (ev_start) begin
        state    <= ST_DEV;
        bitcnt   <= '0;
        sda_oe   <= 1'b0;
        got_data <= 1'b0;
      end else if (ev_stop) begin
        wr_commit <= (state == ST_WR) && got_data;
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        got_data  <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (ev_rise) begin
          if (bitcnt < 4'd8 && state != ST_RD) shreg <= {shreg[6:0], sda_s};
          if (bitcnt == 4'd8 && state == ST_RD) mack <= ~sda_s;
          if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
        end else if (ev_fall) begin
          if (state == ST_RD) begin
            if (bitcnt == 4'd9) begin
              if (mack) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                ptr    <= ADDR_W'(lin_next(16'(ptr), ADDR_W));
                bitcnt <= '0;
              end else begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
              end
            end else if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
            end else begin
              sda_oe <= ~tx[bit_idx];
            end
          end else if (bitcnt == 4'd9) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
          end else if (bitcnt == 4'd8) begin
            case (state)
              ST_DEV: begin
                if (sel_match(shreg, strap) && !wr_busy) begin
                  sda_oe <= 1'b1;
                  mack   <= 1'b1;
                  state  <= shreg[0] ? ST_RD : ST_AHI;
                end else begin
                  sda_oe <= 1'b0;
                  state  <= ST_IDLE;
                end
              end
              ST_AHI: begin
                hi     <= shreg;
                sda_oe <= 1'b1;
                state  <= ST_ALO;
              end
              ST_ALO: begin
                ptr    <= ADDR_W'({hi, shreg});
                sda_oe <= 1'b1;
                state  <= ST_WR;
              end
              ST_WR: begin
                wr_valid <= 1'b1;
                wr_addr  <= ptr;
                wr_data  <= shreg;
                ptr      <= ADDR_W'(page_next(16'(ptr), PAGE_W));
                got_data <= 1'b1;
                sda_oe   <= 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/twm_slave.sv
module twm_slave #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap,
  input  logic              wr_busy,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  logic scl_s, sda_s;
  logic ev_rise, ev_fall, ev_start, ev_stop;
  logic byte_done, sel_done;

  twm_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  twm_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop),
    .strap(strap), .wr_busy(wr_busy), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
    .rd_addr(rd_addr), .rd_data(rd_data), .byte_done(byte_done), .sel_done(sel_done)
  );
endmodule

// File: rtl/twm_checker.sv
module twm_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic ev_fall,
  input logic ev_start,
  input logic ev_stop,
  input logic byte_done,
  input logic sel_done,
  input logic wr_busy,
  input logic wr_valid,
  input logic wr_commit
);
  AST_OE_MOVES_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(ev_fall || ev_start || ev_stop)); // R11

  AST_START_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe); // R10

  AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(ev_stop)); // R5

  AST_STROBE_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(byte_done)); // R3

  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_done && wr_busy) |=> !sda_oe); // R9

  AST_STROBE_COMMIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_commit)); // R5
endmodule

bind twm_slave twm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop),
  .byte_done(byte_done), .sel_done(sel_done), .wr_busy(wr_busy),
  .wr_valid(wr_valid), .wr_commit(wr_commit)
);

// File: tb/twm_slave_bench.sv
module twm_slave_bench;
  localparam int AW = 13;
  localparam int QT = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic wr_busy = 1'b0;
  logic sda_oe, wr_valid, wr_commit;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  int log_n = 0, commit_n = 0, viol_n = 0;
  logic [AW-1:0] log_a [0:63];
  logic [7:0]    log_d [0:63];
  logic scl_p = 1'b1, oe_p = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[12:8], 3'b011};
  endfunction
  assign rd_data = pat(rd_addr);

  twm_slave #(.ADDR_W(AW), .PAGE_W(5)) u_twm_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(STRAP), .wr_busy(wr_busy), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    if (wr_valid && log_n < 64) begin
      log_a[log_n] <= wr_addr;
      log_d[log_n] <= wr_data;
      log_n <= log_n + 1;
    end
    if (wr_commit) commit_n <= commit_n + 1;
    if (rst_n && scl_m && scl_p && (sda_oe != oe_p)) viol_n <= viol_n + 1;
    scl_p <= scl_m;
    oe_p  <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1; tick(QT); scl_m = 1; tick(QT); sda_m = 0; tick(QT); scl_m = 0; tick(QT);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(QT); scl_m = 1; tick(QT); sda_m = 1; tick(2*QT);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(QT); scl_m = 1; tick(2*QT); scl_m = 0; tick(QT);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1; tick(QT); scl_m = 1; tick(QT);
    ack = (sda_line == 1'b0);
    tick(QT); scl_m = 0; tick(QT);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      tick(QT); scl_m = 1; tick(QT); b = {b[6:0], sda_line}; tick(QT); scl_m = 0;
    end
    tick(1); sda_m = mack ? 1'b0 : 1'b1; tick(QT);
    scl_m = 1; tick(2*QT); scl_m = 0; tick(1); sda_m = 1;
  endtask

  task automatic write_addr(input logic [7:0] hb, input logic [7:0] lb, input string tag);
    bit a;
    send_byte({4'b1010, STRAP, 1'b0}, a); chk(a, {tag, " select ack"}, a, 1);
    send_byte(hb, a); chk(a, {tag, " addr hi ack"}, a, 1);
    send_byte(lb, a); chk(a, {tag, " addr lo ack"}, a, 1);
  endtask

  initial begin
    bit a;
    logic [7:0] b;
    int l0, c0;
    tick(5);
    chk(sda_oe == 0 && wr_valid == 0 && wr_commit == 0, "R1 reset outputs", sda_oe, 0);
    rst_n = 1; tick(5);

    // R2: sweep all strap codes plus a wrong device code
    for (int s = 0; s < 8; s++) begin
      bus_start();
      send_byte({4'b1010, 3'(s), 1'b0}, a);
      chk(a == (s == int'(STRAP)), "R2 select strap compare", a, s == int'(STRAP));
      if (!a) begin
        send_byte(8'h00, a);
        chk(!a, "R2 idle after mismatch", a, 0);
      end
      bus_stop();
    end
    bus_start(); send_byte({4'b1011, STRAP, 1'b0}, a);
    chk(!a, "R2 wrong device code", a, 0); bus_stop();

    // R3, R5: write two bytes, upper address bits ignored
    l0 = log_n; c0 = commit_n;
    bus_start(); write_addr(8'hE1, 8'h23, "R3");
    send_byte(8'h5A, a); chk(a, "R3 data ack", a, 1);
    send_byte(8'h3C, a); chk(a, "R3 data ack", a, 1);
    bus_stop(); tick(4);
    chk(log_n == l0 + 2, "R3 strobe count", log_n - l0, 2);
    chk(log_a[l0] == 13'h0123 && log_d[l0] == 8'h5A, "R3 first strobe", log_a[l0], 13'h0123);
    chk(log_a[l0+1] == 13'h0124 && log_d[l0+1] == 8'h3C, "R3 second strobe", log_a[l0+1], 13'h0124);
    chk(commit_n == c0 + 1, "R5 commit after data", commit_n - c0, 1);

    // R6: current address read
    bus_start(); send_byte({4'b1010, STRAP, 1'b1}, a); chk(a, "R6 read select ack", a, 1);
    recv_byte(0, b); bus_stop();
    chk(b == pat(13'h0125), "R6 current read", b, pat(13'h0125));

    // R4: page wrap on writes
    l0 = log_n;
    bus_start(); write_addr(8'h04, 8'h1F, "R4");
    for (int i = 0; i < 3; i++) send_byte(8'hA0 + 8'(i), a);
    bus_stop(); tick(4);
    chk(log_a[l0] == 13'h041F, "R4 page start", log_a[l0], 13'h041F);
    chk(log_a[l0+1] == 13'h0400, "R4 page wrap", log_a[l0+1], 13'h0400);
    chk(log_a[l0+2] == 13'h0401 && log_d[l0+2] == 8'hA2, "R4 after wrap", log_a[l0+2], 13'h0401);

    // R5: address-only write gives no commit
    l0 = log_n; c0 = commit_n;
    bus_start(); write_addr(8'h07, 8'h77, "R5"); bus_stop(); tick(4);
    chk(commit_n == c0 && log_n == l0, "R5 no commit on address only", commit_n - c0, 0);

    // R7: random read
    bus_start(); write_addr(8'h07, 8'h77, "R7");
    bus_start(); send_byte({4'b1010, STRAP, 1'b1}, a); chk(a, "R7 read select ack", a, 1);
    recv_byte(0, b); bus_stop();
    chk(b == pat(13'h0777), "R7 random read", b, pat(13'h0777));

    // R8: sequential read across top of space
    bus_start(); write_addr(8'h1F, 8'hFE, "R8");
    bus_start(); send_byte({4'b1010, STRAP, 1'b1}, a);
    recv_byte(1, b); chk(b == pat(13'h1FFE), "R8 seq byte 0", b, pat(13'h1FFE));
    recv_byte(1, b); chk(b == pat(13'h1FFF), "R8 seq byte 1", b, pat(13'h1FFF));
    recv_byte(0, b); chk(b == pat(13'h0000), "R8 seq wrap", b, pat(13'h0000));
    bus_stop();
    bus_start(); send_byte({4'b1010, STRAP, 1'b1}, a);
    recv_byte(0, b); bus_stop();
    chk(b == pat(13'h0001), "R8 pointer after nack", b, pat(13'h0001));

    // R9: busy polling
    wr_busy = 1; l0 = log_n;
    bus_start(); send_byte({4'b1010, STRAP, 1'b0}, a);
    chk(!a, "R9 no ack while busy", a, 0);
    send_byte(8'h00, a); send_byte(8'h00, a); send_byte(8'h11, a);
    bus_stop(); tick(4);
    chk(log_n == l0, "R9 no strobe while busy", log_n - l0, 0);
    wr_busy = 0;
    bus_start(); send_byte({4'b1010, STRAP, 1'b0}, a);
    chk(a, "R9 ack after busy", a, 1); bus_stop();

    // R10: aborts by start condition
    l0 = log_n; c0 = commit_n;
    bus_start(); send_bits({4'b1010, STRAP, 1'b0}, 4);
    bus_start(); write_addr(8'h00, 8'h10, "R10");
    send_byte(8'h77, a); chk(a, "R10 data ack after abort", a, 1);
    send_bits(8'hFF, 5);
    bus_start(); bus_stop(); tick(4);
    chk(log_n == l0 + 1 && log_a[l0] == 13'h0010 && log_d[l0] == 8'h77,
        "R10 transfer after abort", log_n - l0, 1);
    chk(commit_n == c0, "R5 R10 no commit after abort", commit_n - c0, 0);

    chk(viol_n == 0, "R11 sda_oe stable while scl high", viol_n, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule